// File: doc/BRIEF.md
# Float-Integer Conversion Unit

This block converts one value per request between the IEEE 754 single-precision format and a 32-bit integer, in either direction. A direction select picks float-to-integer or integer-to-float, and a separate select says whether the integer side is signed (two's complement) or unsigned. The result and its two exception indications (invalid and inexact) appear on registered outputs one cycle after a valid strobe, together with a one-cycle done pulse. The block has no comparison condition flags and drives none.

Rounding is chosen per request. Float-to-integer truncates toward zero by default, and uses the configured 2-bit rounding mode only when the caller asks for it. Integer-to-float always uses the configured mode. A float-to-integer conversion that cannot be represented saturates and raises invalid. Any conversion whose result is not exact raises inexact.

Top module: `fcvt_unit`

## Requirements
- R1: For a request accepted with `in_valid` high at a rising clock edge, `out_done` is high for exactly the following cycle and carries that request's result. When `in_valid` is low, `out_done` is low and the result and flag outputs keep their previous values.
- R2: In float-to-integer mode (`to_int`=1) with `use_cfg_rnd`=0, the value is rounded toward zero whatever `cfg_rnd` holds.
- R3: In float-to-integer mode with `use_cfg_rnd`=1, the value is rounded by `cfg_rnd`. The encoding is 00 to nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity, and 11 toward zero.
- R4: In integer-to-float mode (`to_int`=0), the value is always rounded by `cfg_rnd` (same encoding as R3), and `use_cfg_rnd` has no effect.
- R5: With `is_signed`=1, the integer side is two's complement over [-2^31, 2^31-1]. With `is_signed`=0, it is unsigned over [0, 2^32-1]. This applies both to the integer operand and to the integer result.
- R6: A float-to-integer result that lies outside the integer range after rounding saturates and raises invalid. Signed results saturate to 0x7FFFFFFF or 0x80000000. Unsigned results saturate to 0xFFFFFFFF, or to 0 for a negative nonzero result.
- R7: A NaN operand converted to integer gives 0 and raises invalid. An infinity saturates by its sign as in R6 and raises invalid.
- R8: Inexact is raised when the rounded result differs from the operand's exact value. Inexact is never raised together with invalid.
- R9: Integer zero converts to +0.0 (0x00000000) in every rounding mode. Integer-to-float never raises invalid.
- R10: After reset, and until the first request completes, the result, invalid, inexact and done outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 32 | Float bits or integer to convert |
| to_int | input | 1 | 1: float to integer, 0: integer to float |
| is_signed | input | 1 | 1: integer side is signed |
| use_cfg_rnd | input | 1 | Float-to-integer uses `cfg_rnd` instead of toward-zero |
| cfg_rnd | input | 2 | Configured rounding mode |
| out_result | output | 32 | Converted value |
| out_invalid | output | 1 | Invalid exception indication |
| out_inexact | output | 1 | Inexact exception indication |
| out_done | output | 1 | One-cycle pulse with a new result |

## Verification
The single-precision layout and the 32-bit integer width are fixed by the package, so the bench builds the block as it stands, with no parameter overrides. The fixed widths put the exact extremes within reach of directed vectors. These include the signed boundaries ±2^31, the unsigned top 2^32-1, which rounds up across a binade, and the 2^24+1 tie in integer-to-float. The float-to-integer vectors cover halfway cases under all four rounding modes and negative values that round to zero on the unsigned side.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = 127;
    localparam int FIX_W  = 2 * WORD_W;
    localparam int GRS_W  = WORD_W - MANT_W;

    localparam logic [1:0] RND_NEAR  = 2'b00;
    localparam logic [1:0] RND_UP    = 2'b01;
    localparam logic [1:0] RND_DOWN  = 2'b10;
    localparam logic [1:0] RND_ZERO  = 2'b11;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              invalid;
        logic              inexact;
        logic              done;
    } cvt_reg_t;

    // Decide whether a truncated magnitude must be incremented.
    function automatic logic round_inc(input logic neg, input logic lsb,
                                       input logic guard, input logic sticky,
                                       input logic [1:0] mode);
        case (mode)
            RND_NEAR: round_inc = guard & (sticky | lsb);
            RND_UP:   round_inc = ~neg & (guard | sticky);
            RND_DOWN: round_inc = neg & (guard | sticky);
            default:  round_inc = 1'b0;
        endcase
    endfunction

    // Number of zero bits above the leading one.
    function automatic logic [5:0] lead_zeros(input logic [WORD_W-1:0] v);
        lead_zeros = 6'(WORD_W);
        for (int i = 0; i < WORD_W; i++) begin
            if (v[i]) lead_zeros = 6'(WORD_W - 1 - i);
        end
    endfunction
endpackage

// File: rtl/fcvt_f2i.sv
module fcvt_f2i
    import fcvt_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic              is_signed,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] res,
    output logic              invalid,
    output logic              inexact
);
    localparam logic [EXP_W-1:0] EXP_MAX   = '1;
    localparam logic [EXP_W-1:0] EXP_HALF  = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] EXP_OVF   = EXP_W'(BIAS + WORD_W);
    localparam logic [EXP_W-1:0] SH_BASE   = EXP_W'(BIAS - 1 - (WORD_W - MANT_W));
    localparam logic [WORD_W:0]  SMAX_POS  = {2'b00, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W:0]  SMAX_NEG  = {2'b01, {(WORD_W-1){1'b0}}};

    logic                neg, is_nan, is_inf, big;
    logic [EXP_W-1:0]    expo, sh;
    logic [MANT_W-1:0]   mant;
    logic [FIX_W-1:0]    fixed;
    logic [WORD_W-1:0]   ipart;
    logic                guard, sticky, inc;
    logic [WORD_W:0]     mag;
    logic                ovf;

    always_comb begin
        neg    = op[WORD_W-1];
        expo   = op[WORD_W-2 -: EXP_W];
        mant   = {expo != '0, op[FRAC_W-1:0]};
        is_nan = (expo == EXP_MAX) && (op[FRAC_W-1:0] != '0);
        is_inf = (expo == EXP_MAX) && (op[FRAC_W-1:0] == '0);
        big    = expo >= EXP_OVF;
        sh     = expo - SH_BASE;
        fixed  = '0;
        ipart  = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        if (expo < EXP_HALF) begin
            sticky = (expo != '0) || (op[FRAC_W-1:0] != '0);
        end else if (!big) begin
            fixed  = FIX_W'(mant) << sh[5:0];
            ipart  = fixed[FIX_W-1:WORD_W];
            guard  = fixed[WORD_W-1];
            sticky = |fixed[WORD_W-2:0];
        end
        inc = round_inc(neg, ipart[0], guard, sticky, mode);
        mag = {1'b0, ipart} + (WORD_W+1)'(inc);
        if (is_signed) ovf = neg ? (mag > SMAX_NEG) : (mag > SMAX_POS);
        else           ovf = neg ? (mag != '0) : mag[WORD_W];
        ovf = ovf || big;

        invalid = 1'b0;
        inexact = 1'b0;
        if (is_nan) begin
            res     = '0;
            invalid = 1'b1;
        end else if (ovf || is_inf) begin
            invalid = 1'b1;
            if (is_signed) res = neg ? SMAX_NEG[WORD_W-1:0] : SMAX_POS[WORD_W-1:0];
            else           res = neg ? '0 : '1;
        end else begin
            res     = neg ? (~mag[WORD_W-1:0] + 1'b1) : mag[WORD_W-1:0];
            inexact = guard | sticky;
        end
    end
endmodule

// File: rtl/fcvt_i2f.sv
module fcvt_i2f
    import fcvt_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic              is_signed,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] res,
    output logic              inexact
);
    logic              neg, inc;
    logic [WORD_W-1:0] mag, norm;
    logic [5:0]        lz;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W:0]   rounded;

    always_comb begin
        neg     = is_signed & op[WORD_W-1];
        mag     = neg ? (~op + 1'b1) : op;
        lz      = lead_zeros(mag);
        norm    = mag << lz[4:0];
        inc     = round_inc(neg, norm[GRS_W], norm[GRS_W-1], |norm[GRS_W-2:0], mode);
        rounded = {1'b0, norm[WORD_W-1:GRS_W]} + (MANT_W+1)'(inc);
        expo    = EXP_W'(BIAS + WORD_W - 1) - EXP_W'(lz) + EXP_W'(rounded[MANT_W]);
        inexact = norm[GRS_W-1] | (|norm[GRS_W-2:0]);
        if (op == '0) res = '0;
        else res = {neg, expo, rounded[MANT_W] ? {FRAC_W{1'b0}} : rounded[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
    import fcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_operand,
    input  logic              to_int,
    input  logic              is_signed,
    input  logic              use_cfg_rnd,
    input  logic [1:0]        cfg_rnd,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_inexact,
    output logic              out_done
);
    logic [1:0]        f2i_mode;
    logic [WORD_W-1:0] f2i_res, i2f_res;
    logic              f2i_inv, f2i_inx, i2f_inx;
    cvt_reg_t          st_d, st_q;

    assign f2i_mode = use_cfg_rnd ? cfg_rnd : RND_ZERO;

    fcvt_f2i u_f2i (
        .op(in_operand), .is_signed(is_signed), .mode(f2i_mode),
        .res(f2i_res), .invalid(f2i_inv), .inexact(f2i_inx)
    );

    fcvt_i2f u_i2f (
        .op(in_operand), .is_signed(is_signed), .mode(cfg_rnd),
        .res(i2f_res), .inexact(i2f_inx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            if (to_int) begin
                st_d.result  = f2i_res;
                st_d.invalid = f2i_inv;
                st_d.inexact = f2i_inx;
            end else begin
                st_d.result  = i2f_res;
                st_d.invalid = 1'b0;
                st_d.inexact = i2f_inx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_result  = st_q.result;
    assign out_invalid = st_q.invalid;
    assign out_inexact = st_q.inexact;
    assign out_done    = st_q.done;
endmodule

// File: rtl/fcvt_unit_chk.sv
module fcvt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_operand,
    input logic        to_int,
    input logic [1:0]  cfg_rnd,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic        out_inexact,
    input logic        out_done
);
    // R1
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && $stable(out_result) && $stable(out_invalid)));
    // R7
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && to_int && in_operand[30:23] == 8'hFF && in_operand[22:0] != '0)
        |=> (out_result == '0 && out_invalid));
    // R9
    i2f_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !to_int) |=> !out_invalid);
    // R9
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !to_int && in_operand == '0) |=> (out_result == '0 && !out_inexact));
    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> !(out_invalid && out_inexact));
    // R4
    mode_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !to_int && cfg_rnd == 2'b11) |=> (out_result[31] || !out_result[30] || out_result[29:23] <= 7'h1E));
endmodule

bind fcvt_unit fcvt_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .to_int(to_int), .cfg_rnd(cfg_rnd), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact), .out_done(out_done)
);

// File: tb/fcvt_unit_bench.sv
module fcvt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        to_int = 1'b0;
    logic        is_signed = 1'b0;
    logic        use_cfg_rnd = 1'b0;
    logic [1:0]  cfg_rnd = 2'b00;
    logic [31:0] out_result;
    logic        out_invalid, out_inexact, out_done;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    fcvt_unit u_fcvt_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .to_int(to_int), .is_signed(is_signed), .use_cfg_rnd(use_cfg_rnd),
        .cfg_rnd(cfg_rnd), .out_result(out_result), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_done(out_done)
    );

    task automatic check(input string req, input logic [31:0] er,
                         input logic ei, input logic ex, input logic ed);
        total++;
        if (out_result !== er || out_invalid !== ei || out_inexact !== ex || out_done !== ed) begin
            bad++;
            $display("FAIL %s: got res=%h inv=%b inx=%b done=%b, want res=%h inv=%b inx=%b done=%b",
                     req, out_result, out_invalid, out_inexact, out_done, er, ei, ex, ed);
        end
    endtask

    task automatic conv(input logic [31:0] op, input logic ti, input logic sg,
                        input logic uc, input logic [1:0] rm);
        @(negedge clk);
        in_operand = op; to_int = ti; is_signed = sg; use_cfg_rnd = uc; cfg_rnd = rm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_done_hold;
        conv(32'h40E00000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R1", 32'd7, 1'b0, 1'b0, 1'b1);
        in_operand = 32'h7FC00000; to_int = 1'b1;
        @(negedge clk);
        check("R1", 32'd7, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_trunc_default;
        conv(32'h40200000, 1'b1, 1'b1, 1'b0, 2'b01);
        check("R2", 32'd2, 1'b0, 1'b1, 1'b1);
        conv(32'hC0200000, 1'b1, 1'b1, 1'b0, 2'b10);
        check("R2", 32'hFFFFFFFE, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_cfg_round;
        conv(32'h40200000, 1'b1, 1'b1, 1'b1, 2'b00);
        check("R3", 32'd2, 1'b0, 1'b1, 1'b1);
        conv(32'h40600000, 1'b1, 1'b1, 1'b1, 2'b00);
        check("R3", 32'd4, 1'b0, 1'b1, 1'b1);
        conv(32'h40200000, 1'b1, 1'b1, 1'b1, 2'b01);
        check("R3", 32'd3, 1'b0, 1'b1, 1'b1);
        conv(32'hC0200000, 1'b1, 1'b1, 1'b1, 2'b10);
        check("R3", 32'hFFFFFFFD, 1'b0, 1'b1, 1'b1);
        conv(32'hC0200000, 1'b1, 1'b1, 1'b1, 2'b11);
        check("R3", 32'hFFFFFFFE, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_i2f_mode;
        conv(32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 2'b00);
        check("R4", 32'h4F800000, 1'b0, 1'b1, 1'b1);
        conv(32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 2'b11);
        check("R4", 32'h4F7FFFFF, 1'b0, 1'b1, 1'b1);
        conv(32'h01000001, 1'b0, 1'b0, 1'b1, 2'b00);
        check("R4", 32'h4B800000, 1'b0, 1'b1, 1'b1);
        conv(32'h01000001, 1'b0, 1'b0, 1'b0, 2'b01);
        check("R4", 32'h4B800001, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_signedness;
        conv(32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R5", 32'hBF800000, 1'b0, 1'b0, 1'b1);
        conv(32'h80000000, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R5", 32'hCF000000, 1'b0, 1'b0, 1'b1);
        conv(32'h80000000, 1'b0, 1'b0, 1'b0, 2'b00);
        check("R5", 32'h4F000000, 1'b0, 1'b0, 1'b1);
        conv(32'h4F000000, 1'b1, 1'b0, 1'b0, 2'b00);
        check("R5", 32'h80000000, 1'b0, 1'b0, 1'b1);
        conv(32'hCF000000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R5", 32'h80000000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_saturate;
        conv(32'h4F000000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R6", 32'h7FFFFFFF, 1'b1, 1'b0, 1'b1);
        conv(32'h4F800000, 1'b1, 1'b0, 1'b0, 2'b00);
        check("R6", 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1);
        conv(32'hBF800000, 1'b1, 1'b0, 1'b0, 2'b00);
        check("R6", 32'h00000000, 1'b1, 1'b0, 1'b1);
        conv(32'hD0000000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R6", 32'h80000000, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_special;
        conv(32'h7FC00000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R7", 32'h0, 1'b1, 1'b0, 1'b1);
        conv(32'h7F800000, 1'b1, 1'b1, 1'b0, 2'b00);
        check("R7", 32'h7FFFFFFF, 1'b1, 1'b0, 1'b1);
        conv(32'hFF800000, 1'b1, 1'b0, 1'b0, 2'b00);
        check("R7", 32'h0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_inexact;
        conv(32'hBE800000, 1'b1, 1'b0, 1'b0, 2'b00);
        check("R8", 32'h0, 1'b0, 1'b1, 1'b1);
        conv(32'h3F800000, 1'b1, 1'b0, 1'b1, 2'b01);
        check("R8", 32'd1, 1'b0, 1'b0, 1'b1);
        conv(32'h00000007, 1'b0, 1'b1, 1'b0, 2'b00);
        check("R8", 32'h40E00000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_zero;
        conv(32'h0, 1'b0, 1'b1, 1'b0, 2'b10);
        check("R9", 32'h0, 1'b0, 1'b0, 1'b1);
        conv(32'h0, 1'b0, 1'b0, 1'b1, 2'b01);
        check("R9", 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_done_hold;
        t_trunc_default;
        t_cfg_round;
        t_i2f_mode;
        t_signedness;
        t_saturate;
        t_special;
        t_inexact;
        t_zero;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule